// File: doc/BRIEF.md
# Condition Register Field Transfer Unit

This block keeps a 32-bit condition register built from eight 4-bit fields. It moves data between that register and a 64-bit general-purpose operand. One operation is selected per cycle: a write of any subset of fields, a write of one field picked by priority, a read of one field picked by priority, a read of the whole register, or a load of four status flags into one field.

Fields are numbered from the most significant end. Field 0 sits in CR bits [31:28] and field 7 in CR bits [3:0]. Field n lines up with operand bits [31-4n:28-4n]. The field mask is also numbered from the most significant end: mask bit `fieldMask[7-n]` belongs to field n. Writes take effect on the rising clock edge when `valid` is high. Read results are combinational and come from the register value that holds before any update.

Top module: `crxfer_unit`

## Requirements
- R1: A synchronous, active-high `rst` clears the condition register, so `crOut` reads 0 after the reset edge.
- R2: With op 3'd1 (masked write) and `valid` high, every field n whose bit `fieldMask[7-n]` is 1 takes operand bits [31-4n:28-4n] at the clock edge. Every other field keeps its value.
- R3: With op 3'd2 (single write) and `valid` high, only the lowest-numbered field whose mask bit is set is loaded from the operand. Field 0 belongs to `fieldMask[7]`. All other fields keep their values.
- R4: A single write (op 3'd2) with `fieldMask` equal to 0 loads field 7 (CR[3:0]) from `srcData[3:0]`.
- R5: With op 3'd3 (single read), `result` is zero except at bits [31-4n:28-4n]. Those bits hold field n, the lowest-numbered field whose mask bit is set. With a zero mask, `result` is all zeros.
- R6: With op 3'd4 (full read), `result` equals 32 zero bits followed by the 32-bit CR.
- R7: With op 3'd5 (flag load) and `valid` high, the field numbered `fieldIdx` becomes {flagOv, flagOv32, flagCa, flagCa32}, with flagOv as the field's MSB. Other fields are unchanged.
- R8: The CR changes only on an edge with `valid` high and op 3'd1, 3'd2 or 3'd5. Ops 3'd0, 3'd3, 3'd4, 3'd6 and 3'd7, and any op with `valid` low, leave the CR unchanged. `result` is zero for every op other than 3'd3 and 3'd4.
- R9: `crOut` always shows the present register value. A write first appears on `crOut` after its clock edge, and reads in the same cycle see the older value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Qualifies a register update at this edge |
| op | input | 3 | Operation select (see requirements) |
| fieldMask | input | 8 | Field mask, bit 7 belongs to field 0 |
| fieldIdx | input | 3 | Target field of the flag load |
| srcData | input | 64 | Source operand |
| flagOv | input | 1 | Overflow flag |
| flagOv32 | input | 1 | 32-bit overflow flag |
| flagCa | input | 1 | Carry flag |
| flagCa32 | input | 1 | 32-bit carry flag |
| result | output | 64 | Read result |
| crOut | output | 32 | Present condition register |

## Verification
The bench builds the block with its default values: a 64-bit operand and eight 4-bit fields. With these values every one of the 256 mask patterns and every field index can be reached. Directed steps cover empty, single-bit, multi-bit and full masks for both priority rules, flag loads into the first and last fields, and ops that must be ignored. Several hundred pseudo-random steps then mix all eight op codes against a behavioural model.

// File: rtl/crxfer_pkg.sv
package crxfer_pkg;

  localparam int CRX_FIELDS  = 8;
  localparam int CRX_FIELD_W = 4;
  localparam int CRX_CR_W    = CRX_FIELDS * CRX_FIELD_W;
  localparam int CRX_IDX_W   = $clog2(CRX_FIELDS);

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_WR_MASK = 3'd1,
    OP_WR_ONE  = 3'd2,
    OP_RD_ONE  = 3'd3,
    OP_RD_ALL  = 3'd4,
    OP_FLAGS   = 3'd5
  } crOp_t;

  // Strobes from control to datapath; bit n of a field vector is field n.
  typedef struct packed {
    logic [CRX_FIELDS-1:0] fieldWr;
    logic                  loadFlags;
    logic [CRX_FIELDS-1:0] fieldRd;
    logic                  readAll;
  } crCtrl_t;

endpackage

// File: rtl/crxfer_prio.sv
module crxfer_prio #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] grant,
  output logic             found
);

  // Lowest index wins.
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int n = 0; n < WIDTH; n++) begin
      if (req[n] && !found) begin
        grant[n] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/crxfer_ctrl.sv
module crxfer_ctrl
  import crxfer_pkg::*;
#(
  parameter int NF    = CRX_FIELDS,
  parameter int IDX_W = CRX_IDX_W
) (
  input  logic             valid,
  input  logic [2:0]       op,
  input  logic [NF-1:0]    fieldMask,
  input  logic [IDX_W-1:0] fieldIdx,
  output crCtrl_t          ctrl
);

  localparam logic [NF-1:0] LAST_FIELD = NF'(1) << (NF - 1);

  logic [NF-1:0] maskByField;
  logic [NF-1:0] firstSel;
  logic          anySel;
  logic [NF-1:0] idxOneHot;

  // Mask bit NF-1 belongs to field 0.
  for (genvar n = 0; n < NF; n++) begin : g_rev
    assign maskByField[n] = fieldMask[NF-1-n];
  end

  crxfer_prio #(.WIDTH(NF)) u_prio (
    .req  (maskByField),
    .grant(firstSel),
    .found(anySel)
  );

  assign idxOneHot = NF'(1) << fieldIdx;

  always_comb begin
    ctrl = '0;
    unique case (crOp_t'(op))
      OP_WR_MASK: if (valid) ctrl.fieldWr = maskByField;
      OP_WR_ONE:  if (valid) ctrl.fieldWr = anySel ? firstSel : LAST_FIELD;
      OP_FLAGS: begin
        if (valid) ctrl.fieldWr = idxOneHot;
        ctrl.loadFlags = 1'b1;
      end
      OP_RD_ONE:  ctrl.fieldRd = firstSel;
      OP_RD_ALL:  ctrl.readAll = 1'b1;
      default:    ctrl = '0;
    endcase
  end

endmodule

// File: rtl/crxfer_datapath.sv
module crxfer_datapath
  import crxfer_pkg::*;
#(
  parameter int NF     = CRX_FIELDS,
  parameter int FW     = CRX_FIELD_W,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  crCtrl_t           ctrl,
  input  logic [NF*FW-1:0]  srcLow,
  input  logic [FW-1:0]     flags,
  output logic [DATA_W-1:0] result,
  output logic [NF*FW-1:0]  crOut
);

  localparam int CR_W = NF * FW;

  logic [CR_W-1:0] crReg;
  logic [CR_W-1:0] crNext;
  logic [CR_W-1:0] rdPart;

  for (genvar n = 0; n < NF; n++) begin : g_field
    localparam int HI = CR_W - 1 - FW * n;
    logic [FW-1:0] loadVal;
    assign loadVal          = ctrl.loadFlags ? flags : srcLow[HI -: FW];
    assign crNext[HI -: FW] = ctrl.fieldWr[n] ? loadVal : crReg[HI -: FW];
    assign rdPart[HI -: FW] = ctrl.fieldRd[n] ? crReg[HI -: FW] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) crReg <= '0;
    else     crReg <= crNext;
  end

  assign result = {{(DATA_W-CR_W){1'b0}}, (ctrl.readAll ? crReg : rdPart)};
  assign crOut  = crReg;

endmodule

// File: rtl/crxfer_unit.sv
module crxfer_unit
  import crxfer_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid,
  input  logic [2:0]           op,
  input  logic [CRX_FIELDS-1:0] fieldMask,
  input  logic [CRX_IDX_W-1:0] fieldIdx,
  input  logic [DATA_W-1:0]    srcData,
  input  logic                 flagOv,
  input  logic                 flagOv32,
  input  logic                 flagCa,
  input  logic                 flagCa32,
  output logic [DATA_W-1:0]    result,
  output logic [CRX_CR_W-1:0]  crOut
);

  crCtrl_t ctrl;
  logic    unusedSrcHi;

  assign unusedSrcHi = ^srcData[DATA_W-1:CRX_CR_W];

  crxfer_ctrl u_ctrl (
    .valid    (valid),
    .op       (op),
    .fieldMask(fieldMask),
    .fieldIdx (fieldIdx),
    .ctrl     (ctrl)
  );

  crxfer_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .ctrl  (ctrl),
    .srcLow(srcData[CRX_CR_W-1:0]),
    .flags ({flagOv, flagOv32, flagCa, flagCa32}),
    .result(result),
    .crOut (crOut)
  );

endmodule

// File: rtl/crxfer_unit_chk.sv
module crxfer_unit_chk
  import crxfer_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  valid,
  input logic [2:0]            op,
  input logic [CRX_FIELDS-1:0] fieldMask,
  input logic [CRX_IDX_W-1:0]  fieldIdx,
  input logic [DATA_W-1:0]     srcData,
  input logic                  flagOv,
  input logic                  flagOv32,
  input logic                  flagCa,
  input logic                  flagCa32,
  input logic [DATA_W-1:0]     result,
  input logic [CRX_CR_W-1:0]   crOut
);

  localparam int NF  = CRX_FIELDS;
  localparam int FW  = CRX_FIELD_W;
  localparam int CRW = CRX_CR_W;

  logic [CRW-1:0]       maskBits;
  logic [CRW-1:0]       prevCr;
  logic [NF-1:0]        fieldChg;
  logic [FW-1:0]        lastFlags;
  logic [CRX_IDX_W-1:0] lastIdx;
  logic [FW-1:0]        fieldAtLast;
  logic                 unusedHi;

  assign unusedHi = ^srcData[DATA_W-1:CRW];

  for (genvar n = 0; n < NF; n++) begin : g_exp
    assign maskBits[CRW-1-FW*n -: FW] = {FW{fieldMask[NF-1-n]}};
    assign fieldChg[n] = |(crOut[CRW-1-FW*n -: FW] ^ prevCr[CRW-1-FW*n -: FW]);
  end

  always_ff @(posedge clk) begin
    prevCr    <= crOut;
    lastFlags <= {flagOv, flagOv32, flagCa, flagCa32};
    lastIdx   <= fieldIdx;
  end

  assign fieldAtLast = crOut[CRW - 1 - FW * int'(lastIdx) -: FW];

  a_r2_unmasked_keep: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_WR_MASK) |=> (((crOut ^ $past(crOut)) & ~$past(maskBits)) == '0));

  a_r2_masked_load: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_WR_MASK) |=> ((crOut & $past(maskBits)) == ($past(srcData[CRW-1:0]) & $past(maskBits))));

  a_r3_one_field: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_WR_ONE) |=> $onehot0(fieldChg));

  a_r4_default_field: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_WR_ONE && fieldMask == '0) |=>
      (crOut == {$past(crOut[CRW-1:FW]), $past(srcData[FW-1:0])}));

  a_r5_empty_read: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RD_ONE && fieldMask == '0) |-> (result == '0));

  a_r6_full_read: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RD_ALL) |-> (result == {{(DATA_W-CRW){1'b0}}, crOut}));

  a_r7_flag_copy: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_FLAGS) |=> (fieldAtLast == lastFlags));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!valid) |=> $stable(crOut));

endmodule

bind crxfer_unit crxfer_unit_chk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rst(rst), .valid(valid), .op(op), .fieldMask(fieldMask),
  .fieldIdx(fieldIdx), .srcData(srcData), .flagOv(flagOv), .flagOv32(flagOv32),
  .flagCa(flagCa), .flagCa32(flagCa32), .result(result), .crOut(crOut)
);

// File: tb/crxfer_unit_test.sv
`timescale 1ns/1ps
module crxfer_unit_test;

  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid;
  logic [2:0]  op;
  logic [7:0]  fieldMask;
  logic [2:0]  fieldIdx;
  logic [63:0] srcData;
  logic        flagOv, flagOv32, flagCa, flagCa32;
  logic [63:0] result;
  logic [31:0] crOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] refCr;

  always #(CLK_P/2) clk = ~clk;

  crxfer_unit uut (
    .clk(clk), .rst(rst), .valid(valid), .op(op), .fieldMask(fieldMask),
    .fieldIdx(fieldIdx), .srcData(srcData), .flagOv(flagOv), .flagOv32(flagOv32),
    .flagCa(flagCa), .flagCa32(flagCa32), .result(result), .crOut(crOut)
  );

  function automatic logic [3:0] getF(logic [31:0] cr, int n);
    return cr[31 - 4*n -: 4];
  endfunction

  function automatic logic [31:0] setF(logic [31:0] cr, int n, logic [3:0] v);
    logic [31:0] c = cr;
    c[31 - 4*n -: 4] = v;
    return c;
  endfunction

  function automatic string tagFor(logic [2:0] o);
    case (o)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] expResult(logic [2:0] o, logic [7:0] m, logic [31:0] cr);
    logic [63:0] r = '0;
    if (o == 3'd4) r = {32'b0, cr};
    else if (o == 3'd3) begin
      for (int n = 0; n < 8; n++) begin
        if (m[7-n]) begin
          r[31 - 4*n -: 4] = getF(cr, n);
          break;
        end
      end
    end
    return r;
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive after a falling edge, check mid-cycle, then advance the model at the rising edge.
  task automatic step(string tag, logic v, logic [2:0] o, logic [7:0] m,
                      logic [2:0] idx, logic [63:0] src, logic [3:0] fl);
    valid = v; op = o; fieldMask = m; fieldIdx = idx; srcData = src;
    {flagOv, flagOv32, flagCa, flagCa32} = fl;
    #2;
    check64({"R9 crOut ", tag}, {32'b0, crOut}, {32'b0, refCr});
    check64({tag, " result"}, result, expResult(o, m, refCr));
    @(posedge clk);
    if (v) begin
      case (o)
        3'd1: for (int n = 0; n < 8; n++) if (m[7-n]) refCr = setF(refCr, n, src[31 - 4*n -: 4]);
        3'd2: begin
          int sel = 7;
          for (int n = 7; n >= 0; n--) if (m[7-n]) sel = n;
          refCr = setF(refCr, sel, src[31 - 4*sel -: 4]);
        end
        3'd5: refCr = setF(refCr, int'(idx), fl);
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    refCr = '0;
    #2;
    check64("R1 reset", {32'b0, crOut}, 64'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; valid = 1'b0; op = '0; fieldMask = '0; fieldIdx = '0;
    srcData = '0; {flagOv, flagOv32, flagCa, flagCa32} = '0;
    @(negedge clk);
    doReset();

    // R2: full, empty, single and sparse masks
    step("R2 all", 1, 3'd1, 8'hFF, 0, 64'hDEAD_BEEF_1234_5678, 0);
    step("R2 none", 1, 3'd1, 8'h00, 0, 64'h0, 0);
    step("R2 one", 1, 3'd1, 8'h10, 0, 64'hFFFF_FFFF_0000_0000 | 64'h000A_0000, 0);
    step("R2 sparse", 1, 3'd1, 8'hA5, 0, 64'h0123_4567_89AB_CDEF, 0);
    // R3/R4: priority and fallback
    step("R3 prio", 1, 3'd2, 8'h24, 0, 64'h0000_0000_FFFF_FFFF, 0);
    step("R3 top", 1, 3'd2, 8'hFF, 0, 64'h0000_0000_0000_0000, 0);
    step("R4 empty", 1, 3'd2, 8'h00, 0, 64'h0000_0000_0000_0009, 0);
    // R5/R6 reads
    step("R5 empty", 1, 3'd3, 8'h00, 0, 0, 0);
    step("R5 prio", 1, 3'd3, 8'h03, 0, 0, 0);
    step("R5 first", 0, 3'd3, 8'hFF, 0, 0, 0);
    step("R6 all", 1, 3'd4, 8'h00, 0, 0, 0);
    // R7 flag order and ends
    step("R7 f0", 1, 3'd5, 8'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1000);
    step("R7 f7", 1, 3'd5, 8'hFF, 3'd7, 0, 4'b0011);
    step("R7 f3", 1, 3'd5, 8'h00, 3'd3, 0, 4'b0101);
    // R8 ignored writes and unused codes
    step("R8 novalid", 0, 3'd1, 8'hFF, 0, 64'h5555_5555_5555_5555, 0);
    step("R8 novalid1", 0, 3'd5, 8'h00, 3'd2, 0, 4'hF);
    step("R8 op6", 1, 3'd6, 8'hFF, 0, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF);
    step("R8 op7", 1, 3'd7, 8'hFF, 0, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF);
    step("R8 op0", 1, 3'd0, 8'hFF, 0, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF);
    step("R6 after", 0, 3'd4, 8'h00, 0, 0, 0);

    for (int i = 0; i < 600; i++) begin
      logic [2:0] o = 3'($urandom_range(0, 7));
      logic [7:0] m;
      case ($urandom_range(0, 3))
        0: m = 8'h00;
        1: m = 8'h01 << $urandom_range(0, 7);
        default: m = 8'($urandom);
      endcase
      step(tagFor(o), 1'($urandom_range(0, 4) != 0), o, m, 3'($urandom_range(0, 7)),
           {$urandom, $urandom}, 4'($urandom));
    end

    step("R2 prereset", 1, 3'd1, 8'hFF, 0, 64'hFFFF_FFFF, 0);
    doReset();
    step("R6 postreset", 0, 3'd4, 8'h00, 0, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule